// File: doc/BRIEF.md
# Modem Line Event Mask and Wake Logic

This block watches the four modem status lines (clear-to-send, data-set-ready, ring indicator, data-carrier-detect) and the serial receive line of a UART. It detects status changes on them, records the modem changes in sticky flags, and sends each change to up to three places: the modem-status interrupt, a power-management event output used while the device sits in a low-power state, and a wake request used while the UART is in automatic sleep. A mask register holds one disable bit per source. That bit closes all three paths for its source at once. The receive line has its own mask bit, and a start-bit transition on it can only raise the power-management event.

All line inputs are synchronised, active-high status levels (1 = asserted). On every clock the block compares each line with its value on the previous clock. Any change on clear-to-send, data-set-ready or data-carrier-detect counts as an event. A ring indicator counts only when it goes from asserted to deasserted. The receive line counts only on a high-to-low transition. Power-state sequencing is handled elsewhere; the block only reads the low-power and sleeping indicators.

Top module: `mdm_evt_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the delta flags, the interrupt, the power-management event, the wake request and all mask bits, so every source is enabled once reset is released.
- R2: A change in either direction on CTS, DSR or DCD sets delta_o bit 0, 1 or 3 respectively at the clock edge that first samples the new level.
- R3: RI sets delta_o bit 2 only on a change from 1 to 0. A change from 0 to 1 sets no flag and raises no output.
- R4: Delta flags stay set until msr_rd_i is sampled high, which clears them all. A new event in the same cycle as the read leaves its flag set.
- R5: irq_o is registered at the same edge as the flags. It equals msi_en_i AND the OR of (updated flags AND NOT the modem mask bits).
- R6: pme_o pulses for one cycle at the edge that samples an unmasked modem event, provided lowpwr_i is high in that cycle.
- R7: wake_o pulses for one cycle at the edge that samples an unmasked modem event, provided asleep_i is high in that cycle.
- R8: Setting modem mask bit n (bit 0 = CTS, 1 = DSR, 2 = RI, 3 = DCD) blocks that source from irq_o, pme_o and wake_o. Its delta flag is still recorded.
- R9: A 1-to-0 transition on sin_i pulses pme_o while lowpwr_i is high and sin_mask is clear. It never touches delta_o, irq_o or wake_o. A 0-to-1 transition on sin_i has no effect, and sin_mask set blocks the pulse.
- R10: A mask write (mask_we_i high) is stored at the clock edge and governs events sampled at later edges. An event sampled at the write edge uses the old mask.
- R11: Lines held at any constant level through reset and after it produce no flag or output when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_i | input | 1 | Clear-to-send status level |
| dsr_i | input | 1 | Data-set-ready status level |
| ri_i | input | 1 | Ring indicator status level |
| dcd_i | input | 1 | Data-carrier-detect status level |
| sin_i | input | 1 | Serial receive line (idle high) |
| mask_we_i | input | 1 | Mask register write strobe |
| mdm_mask_i | input | 4 | Modem source disable bits, bit order CTS, DSR, RI, DCD from bit 0 |
| sin_mask_i | input | 1 | Receive-line wake source disable bit |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| lowpwr_i | input | 1 | Device is in the low-power state |
| asleep_i | input | 1 | UART is in automatic sleep |
| msr_rd_i | input | 1 | Modem status read strobe, clears flags |
| irq_o | output | 1 | Modem-status interrupt request (level) |
| pme_o | output | 1 | Power-management event pulse |
| wake_o | output | 1 | Wake request pulse |
| delta_o | output | 4 | Latched delta flags, bit order CTS, DSR, RI, DCD from bit 0 |

## Verification
Three coincidences are provoked on purpose. In the first, a status read strobe meets a new falling RI edge; the flag must come out set, and the interrupt must stay high. In the second, a mask write lands while the flags are being cleared; the mask must only affect events sampled after that edge. In the third, a single line change arrives while both lowpwr_i and asleep_i are high; the power-management pulse, the wake pulse and the interrupt must all rise at the same edge. Each outcome is judged one clock after stimulus, against values derived from the rules above.

// File: rtl/mdm_evt_pkg.sv
package mdm_evt_pkg;
  localparam int NUM_MODEM = 4;

  typedef enum int {
    SRC_CTS = 0,
    SRC_DSR = 1,
    SRC_RI  = 2,
    SRC_DCD = 3
  } modem_src_e;

  // sources that count only the asserted-to-deasserted change
  localparam logic [NUM_MODEM-1:0] TRAIL_ONLY = 4'b0100;
endpackage

// File: rtl/mdm_edge_det.sv
module mdm_edge_det #(
  parameter int                W         = 4,
  parameter logic [W-1:0]      FALL_ONLY = '0
) (
  input  logic         clk,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q;

  // history follows the lines also during reset, so no event at reset exit
  always_ff @(posedge clk) begin
    prev_q <= line_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_src
    if (FALL_ONLY[i]) begin : g_fall
      assign evt_o[i] = prev_q[i] & ~line_i[i];
    end else begin : g_any
      assign evt_o[i] = prev_q[i] ^ line_i[i];
    end
  end
endmodule

// File: rtl/mdm_delta_latch.sv
module mdm_delta_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  output logic [W-1:0] flags_d_o,
  output logic [W-1:0] flags_q_o
);
  // a new event beats a same-cycle clear
  assign flags_d_o = (flags_q_o & ~{W{clr_i}}) | evt_i;

  always_ff @(posedge clk) begin
    if (rst) flags_q_o <= '0;
    else     flags_q_o <= flags_d_o;
  end
endmodule

// File: rtl/mdm_route.sv
module mdm_route #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] flags_d_i,
  input  logic [W-1:0] mask_i,
  input  logic         sin_evt_i,
  input  logic         sin_mask_i,
  input  logic         irq_en_i,
  input  logic         lowpwr_i,
  input  logic         asleep_i,
  output logic         irq_o,
  output logic         pme_o,
  output logic         wake_o
);
  logic modem_hit;
  logic sin_hit;
  logic flag_hit;

  assign modem_hit = |(evt_i & ~mask_i);
  assign sin_hit   = sin_evt_i & ~sin_mask_i;
  assign flag_hit  = |(flags_d_i & ~mask_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      pme_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= irq_en_i & flag_hit;
      pme_o  <= lowpwr_i & (modem_hit | sin_hit);
      wake_o <= asleep_i & modem_hit;
    end
  end
endmodule

// File: rtl/mdm_evt_ctrl.sv
module mdm_evt_ctrl
  import mdm_evt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cts_i,
  input  logic                 dsr_i,
  input  logic                 ri_i,
  input  logic                 dcd_i,
  input  logic                 sin_i,
  input  logic                 mask_we_i,
  input  logic [NUM_MODEM-1:0] mdm_mask_i,
  input  logic                 sin_mask_i,
  input  logic                 msi_en_i,
  input  logic                 lowpwr_i,
  input  logic                 asleep_i,
  input  logic                 msr_rd_i,
  output logic                 irq_o,
  output logic                 pme_o,
  output logic                 wake_o,
  output logic [NUM_MODEM-1:0] delta_o
);
  logic [NUM_MODEM-1:0] lines;
  logic [NUM_MODEM-1:0] modem_evt;
  logic [NUM_MODEM-1:0] flags_d;
  logic [NUM_MODEM-1:0] mdm_mask_q;
  logic                 sin_mask_q;
  logic                 sin_evt;

  always_comb begin
    lines          = '0;
    lines[SRC_CTS] = cts_i;
    lines[SRC_DSR] = dsr_i;
    lines[SRC_RI]  = ri_i;
    lines[SRC_DCD] = dcd_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mdm_mask_q <= '0;
      sin_mask_q <= 1'b0;
    end else if (mask_we_i) begin
      mdm_mask_q <= mdm_mask_i;
      sin_mask_q <= sin_mask_i;
    end
  end

  mdm_edge_det #(.W(NUM_MODEM), .FALL_ONLY(TRAIL_ONLY)) u_modem_edge (
    .clk    (clk),
    .line_i (lines),
    .evt_o  (modem_evt)
  );

  mdm_edge_det #(.W(1), .FALL_ONLY(1'b1)) u_sin_edge (
    .clk    (clk),
    .line_i (sin_i),
    .evt_o  (sin_evt)
  );

  mdm_delta_latch #(.W(NUM_MODEM)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (modem_evt),
    .clr_i     (msr_rd_i),
    .flags_d_o (flags_d),
    .flags_q_o (delta_o)
  );

  mdm_route #(.W(NUM_MODEM)) u_route (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (modem_evt),
    .flags_d_i  (flags_d),
    .mask_i     (mdm_mask_q),
    .sin_evt_i  (sin_evt),
    .sin_mask_i (sin_mask_q),
    .irq_en_i   (msi_en_i),
    .lowpwr_i   (lowpwr_i),
    .asleep_i   (asleep_i),
    .irq_o      (irq_o),
    .pme_o      (pme_o),
    .wake_o     (wake_o)
  );
endmodule

// File: rtl/mdm_evt_ctrl_chk.sv
module mdm_evt_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       msi_en_i,
  input logic       lowpwr_i,
  input logic       asleep_i,
  input logic       msr_rd_i,
  input logic       irq_o,
  input logic       pme_o,
  input logic       wake_o,
  input logic [3:0] delta_o
);
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(msi_en_i)); // R5
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (delta_o != 4'b0000)); // R5
  AST_PME_NEEDS_LOWPWR: assert property (@(posedge clk) disable iff (rst)
    pme_o |-> $past(lowpwr_i)); // R6
  AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(asleep_i)); // R7
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (|($past(delta_o) & ~delta_o)) |-> $past(msr_rd_i)); // R4
endmodule

bind mdm_evt_ctrl mdm_evt_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .msi_en_i (msi_en_i),
  .lowpwr_i (lowpwr_i),
  .asleep_i (asleep_i),
  .msr_rd_i (msr_rd_i),
  .irq_o    (irq_o),
  .pme_o    (pme_o),
  .wake_o   (wake_o),
  .delta_o  (delta_o)
);

// File: tb/mdm_evt_ctrl_tb_top.sv
module mdm_evt_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] modem;   // bit0 CTS, bit1 DSR, bit2 RI, bit3 DCD
  logic       sin;
  logic       mask_we;
  logic [3:0] mdm_mask;
  logic       sin_mask;
  logic       en, lp, sl, rd;
  logic       irq, pme, wake;
  logic [3:0] delta;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mdm_evt_ctrl dut_i (
    .clk        (clk),
    .rst        (rst),
    .cts_i      (modem[0]),
    .dsr_i      (modem[1]),
    .ri_i       (modem[2]),
    .dcd_i      (modem[3]),
    .sin_i      (sin),
    .mask_we_i  (mask_we),
    .mdm_mask_i (mdm_mask),
    .sin_mask_i (sin_mask),
    .msi_en_i   (en),
    .lowpwr_i   (lp),
    .asleep_i   (sl),
    .msr_rd_i   (rd),
    .irq_o      (irq),
    .pme_o      (pme),
    .wake_o     (wake),
    .delta_o    (delta)
  );

  typedef struct packed {
    logic [3:0] modem;
    logic       sin;
    logic       we;
    logic [4:0] wd;      // {sin mask, modem mask[3:0]}
    logic       en, lp, sl, rd;
    logic [3:0] e_delta;
    logic       e_irq, e_pme, e_wake;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{4'b0000,1'b1,1'b0,5'b00000,1'b1,1'b0,1'b0,1'b0, 4'b0000,1'b0,1'b0,1'b0, 4'd5},  // R5 idle
    '{4'b0001,1'b1,1'b0,5'b00000,1'b1,1'b0,1'b0,1'b0, 4'b0001,1'b1,1'b0,1'b0, 4'd2},  // R2 CTS rise
    '{4'b0001,1'b1,1'b0,5'b00000,1'b1,1'b0,1'b0,1'b1, 4'b0000,1'b0,1'b0,1'b0, 4'd4},  // R4 read clears
    '{4'b0011,1'b1,1'b0,5'b00000,1'b0,1'b0,1'b0,1'b0, 4'b0010,1'b0,1'b0,1'b0, 4'd5},  // R5 disabled
    '{4'b0011,1'b1,1'b0,5'b00000,1'b1,1'b0,1'b0,1'b0, 4'b0010,1'b1,1'b0,1'b0, 4'd5},  // R5 enable late
    '{4'b0111,1'b1,1'b0,5'b00000,1'b1,1'b0,1'b0,1'b0, 4'b0010,1'b1,1'b0,1'b0, 4'd3},  // R3 RI rise
    '{4'b0011,1'b1,1'b0,5'b00000,1'b1,1'b0,1'b0,1'b1, 4'b0100,1'b1,1'b0,1'b0, 4'd4},  // R4 read+event
    '{4'b0011,1'b1,1'b0,5'b00000,1'b1,1'b0,1'b0,1'b1, 4'b0000,1'b0,1'b0,1'b0, 4'd4},  // R4
    '{4'b1011,1'b1,1'b0,5'b00000,1'b1,1'b1,1'b0,1'b0, 4'b1000,1'b1,1'b1,1'b0, 4'd6},  // R6 DCD pme
    '{4'b1011,1'b1,1'b0,5'b00000,1'b1,1'b1,1'b0,1'b0, 4'b1000,1'b1,1'b0,1'b0, 4'd6},  // R6 one pulse
    '{4'b1010,1'b1,1'b0,5'b00000,1'b1,1'b0,1'b1,1'b1, 4'b0001,1'b1,1'b0,1'b1, 4'd7},  // R7 wake
    '{4'b1010,1'b1,1'b1,5'b00001,1'b1,1'b0,1'b0,1'b1, 4'b0000,1'b0,1'b0,1'b0, 4'd10}, // R10 mask CTS
    '{4'b1011,1'b1,1'b0,5'b00000,1'b1,1'b1,1'b1,1'b0, 4'b0001,1'b0,1'b0,1'b0, 4'd8},  // R8 masked
    '{4'b1011,1'b1,1'b1,5'b00000,1'b1,1'b0,1'b0,1'b1, 4'b0000,1'b0,1'b0,1'b0, 4'd10}, // R10 unmask
    '{4'b1010,1'b1,1'b0,5'b00000,1'b1,1'b1,1'b1,1'b0, 4'b0001,1'b1,1'b1,1'b1, 4'd10}, // R10 all three
    '{4'b1010,1'b0,1'b0,5'b00000,1'b1,1'b1,1'b1,1'b1, 4'b0000,1'b0,1'b1,1'b0, 4'd9},  // R9 sin fall
    '{4'b1010,1'b1,1'b0,5'b00000,1'b1,1'b1,1'b1,1'b0, 4'b0000,1'b0,1'b0,1'b0, 4'd9},  // R9 sin rise
    '{4'b1010,1'b1,1'b1,5'b10000,1'b1,1'b0,1'b0,1'b0, 4'b0000,1'b0,1'b0,1'b0, 4'd10}, // R10 mask sin
    '{4'b1010,1'b0,1'b0,5'b00000,1'b1,1'b1,1'b1,1'b0, 4'b0000,1'b0,1'b0,1'b0, 4'd9},  // R9 sin masked
    '{4'b1010,1'b1,1'b0,5'b00000,1'b1,1'b0,1'b0,1'b0, 4'b0000,1'b0,1'b0,1'b0, 4'd9},  // R9
    '{4'b1010,1'b1,1'b1,5'b01111,1'b1,1'b0,1'b0,1'b0, 4'b0000,1'b0,1'b0,1'b0, 4'd10}, // R10 mask modem
    '{4'b0100,1'b1,1'b0,5'b00000,1'b1,1'b1,1'b1,1'b0, 4'b1010,1'b0,1'b0,1'b0, 4'd8},  // R8 flags only
    '{4'b0000,1'b1,1'b0,5'b00000,1'b1,1'b1,1'b1,1'b1, 4'b0100,1'b0,1'b0,1'b0, 4'd8},  // R8 RI masked
    '{4'b0000,1'b1,1'b1,5'b01011,1'b1,1'b0,1'b0,1'b1, 4'b0000,1'b0,1'b0,1'b0, 4'd10}, // R10 unmask RI
    '{4'b0100,1'b1,1'b0,5'b00000,1'b1,1'b1,1'b1,1'b0, 4'b0000,1'b0,1'b0,1'b0, 4'd3},  // R3 rise ignored
    '{4'b0000,1'b1,1'b0,5'b00000,1'b1,1'b1,1'b1,1'b0, 4'b0100,1'b1,1'b1,1'b1, 4'd3}   // R3 trailing edge
  };

  task automatic check(input string tag, input logic [3:0] e_d,
                       input logic e_i, input logic e_p, input logic e_w);
    n_chk++;
    if (delta !== e_d || irq !== e_i || pme !== e_p || wake !== e_w) begin
      n_fail++;
      $display("FAIL %s: delta=%b irq=%b pme=%b wake=%b, expected delta=%b irq=%b pme=%b wake=%b",
               tag, delta, irq, pme, wake, e_d, e_i, e_p, e_w);
    end
  endtask

  task automatic drive(input logic [3:0] m, input logic s, input logic we,
                       input logic [4:0] wd, input logic e, input logic l,
                       input logic z, input logic r);
    @(negedge clk);
    modem = m; sin = s; mask_we = we; mdm_mask = wd[3:0]; sin_mask = wd[4];
    en = e; lp = l; sl = z; rd = r;
    @(posedge clk);
    #2;
  endtask

  initial begin
    rst = 1'b1; modem = 4'b1111; sin = 1'b0; mask_we = 1'b0;
    mdm_mask = 4'b0000; sin_mask = 1'b0; en = 1'b1; lp = 1'b1; sl = 1'b1; rd = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset state", 4'b0000, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    check("R11 reset exit, lines high", 4'b0000, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #2;
    check("R11 lines steady", 4'b0000, 1'b0, 1'b0, 1'b0);

    // second reset with the lines at the table's start level
    @(negedge clk);
    rst = 1'b1; modem = 4'b0000; sin = 1'b1; en = 1'b0; lp = 1'b0; sl = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].modem, VECS[i].sin, VECS[i].we, VECS[i].wd,
            VECS[i].en, VECS[i].lp, VECS[i].sl, VECS[i].rd);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            VECS[i].e_delta, VECS[i].e_irq, VECS[i].e_pme, VECS[i].e_wake);
    end

    // R1: reset mid-run clears flags and mask (CTS was masked before)
    @(negedge clk);
    mask_we = 1'b0; rd = 1'b0; rst = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    check("R1 reset clears flags", 4'b0000, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    drive(4'b0001, 1'b1, 1'b0, 5'b00000, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R1 mask cleared by reset", 4'b0001, 1'b1, 1'b1, 1'b1);
    drive(4'b0001, 1'b1, 1'b0, 5'b00000, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R6 R7 pulses end", 4'b0001, 1'b1, 1'b0, 1'b0);
    drive(4'b0000, 1'b1, 1'b0, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R2 CTS fall with read", 4'b0001, 1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule